// File: doc/BRIEF.md
# Standby Clock-Gating Controller

This block lets a pipelined core drop into a low-power standby state and come back out. When the core retires a wait instruction from its write-back stage, the controller reports that interrupts have been turned on. If the system bus is quiet at that moment, it also removes the core clock enable, so the pipeline freezes in place. When the bus is still busy, the request is held as pending and taken on the first cycle the bus goes quiet. The request is dropped if an interrupt arrives before then.

The controller's own logic runs from the free-running clock and never from the gated one. This keeps the six interrupt lines, the non-maskable interrupt, the external bus request and both reset requests visible while the core sleeps. Any enabled interrupt ends standby, and the clock enable returns one cycle after the interrupt is sampled. A reset or cold-reset request always forces the core clock back on and discards a pending entry. An external bus request counts as "bus not idle" for entry purposes, but it does not wake the core.

Top module: `stby_gate_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, `core_clk_en` is 1, `stby_flag` is 0 and `irq_en_set` is 0.
- R2: A `wait_done` sampled high with `bus_idle`=1, `ext_req`=0, no interrupt and no reset request makes `stby_flag`=1 and `core_clk_en`=0 from the next cycle.
- R3: A `wait_done` sampled with `bus_idle`=0 or `ext_req`=1 leaves `core_clk_en`=1 in the next cycle and records a pending entry.
- R4: While an entry is pending, the first sampled cycle with `bus_idle`=1 and `ext_req`=0 (and no interrupt or reset request) makes `stby_flag`=1 in the following cycle.
- R5: An interrupt sampled while an entry is pending cancels it; a later idle bus then causes no standby.
- R6: In standby, any of `irq[5:0]` or `nmi` sampled high (with the default all-enabled wake mask) returns `core_clk_en` to 1 and `stby_flag` to 0 in the next cycle.
- R7: In standby, `ext_req`, `bus_idle` and `wait_done` have no effect; `stby_flag` stays 1.
- R8: `reset_req` or `cold_reset_req` sampled high forces `core_clk_en`=1 next cycle from any state and clears a pending entry.
- R9: `irq_en_set` is a one-cycle pulse in the cycle after `wait_done` is sampled high outside standby without a reset request.
- R10: `stby_flag` always equals the inverse of `core_clk_en`.
- R11: Priority at an edge is reset request, then interrupt, then entry; a `wait_done` coinciding with an interrupt causes no standby or pending entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset of the controller |
| wait_done | input | 1 | Pulse: wait instruction completed write-back |
| bus_idle | input | 1 | System bus has no transaction in flight |
| ext_req | input | 1 | External master requests the bus |
| irq | input | N_IRQ (6) | Maskable interrupt lines, active high |
| nmi | input | 1 | Non-maskable interrupt, active high |
| reset_req | input | 1 | Core warm-reset request |
| cold_reset_req | input | 1 | Core cold-reset request |
| core_clk_en | output | 1 | Core clock enable, 0 while in standby |
| stby_flag | output | 1 | Standby status |
| irq_en_set | output | 1 | Pulse telling the core to turn interrupts on |

## Verification
A wrong internal state shows up at the ports within one cycle. A lost pending entry leaves `core_clk_en` high on the cycle after the bus goes idle. A stale pending entry drops `core_clk_en` after an interrupt or reset should have cleared it. A missed wake keeps `stby_flag` high one cycle after an interrupt is sampled. The bench therefore samples just after each edge: it sweeps every input combination from the running state, walks each wake source out of standby, and varies the busy delay before a pending entry is taken.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_PEND = 2'd1,
        ST_STBY = 2'd2
    } stby_state_e;

    typedef struct packed {
        logic force_run;   // reset or cold-reset request
        logic wake;        // any enabled interrupt or nmi
        logic quiet;       // bus idle and no external request
        logic retire;      // wait instruction retired
    } stby_evt_t;

    function automatic stby_state_e stby_next(input stby_state_e cur, input stby_evt_t ev);
        stby_state_e nx;
        nx = cur;
        if (ev.force_run) begin
            nx = ST_RUN;
        end else begin
            unique case (cur)
                ST_RUN: begin
                    if (ev.retire && !ev.wake)
                        nx = ev.quiet ? ST_STBY : ST_PEND;
                end
                ST_PEND: begin
                    if (ev.wake)
                        nx = ST_RUN;
                    else if (ev.quiet)
                        nx = ST_STBY;
                end
                ST_STBY: begin
                    if (ev.wake)
                        nx = ST_RUN;
                end
                default: nx = ST_RUN;
            endcase
        end
        return nx;
    endfunction

endpackage

// File: rtl/stby_wake_detect.sv
module stby_wake_detect
    import stby_pkg::*;
#(
    parameter int          N_IRQ         = 6,
    parameter logic [N_IRQ-1:0] IRQ_WAKE_MASK = '1
) (
    input  logic [N_IRQ-1:0] irq,
    input  logic             nmi,
    input  logic             wait_done,
    input  logic             bus_idle,
    input  logic             ext_req,
    input  logic             reset_req,
    input  logic             cold_reset_req,
    output stby_evt_t        evt
);
    logic [N_IRQ-1:0] line_wake;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        if (IRQ_WAKE_MASK[i]) begin : g_on
            assign line_wake[i] = irq[i];
        end else begin : g_off
            assign line_wake[i] = 1'b0;
        end
    end

    always_comb begin
        evt.force_run = reset_req | cold_reset_req;
        evt.wake      = (|line_wake) | nmi;
        evt.quiet     = bus_idle & ~ext_req;
        evt.retire    = wait_done;
    end
endmodule

// File: rtl/stby_seq_fsm.sv
module stby_seq_fsm
    import stby_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  stby_evt_t   evt,
    output stby_state_e state
);
    stby_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_RUN;
        else
            state_q <= stby_next(state_q, evt);
    end

    assign state = state_q;
endmodule

// File: rtl/stby_out_stage.sv
module stby_out_stage
    import stby_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  stby_state_e state,
    input  stby_evt_t   evt,
    output logic        core_clk_en,
    output logic        stby_flag,
    output logic        irq_en_set
);
    logic pulse_q;

    always_ff @(posedge clk) begin
        if (rst)
            pulse_q <= 1'b0;
        else
            pulse_q <= evt.retire & ~evt.force_run & (state != ST_STBY);
    end

    always_comb begin
        stby_flag   = (state == ST_STBY);
        core_clk_en = ~stby_flag;
        irq_en_set  = pulse_q;
    end
endmodule

// File: rtl/stby_gate_ctrl.sv
module stby_gate_ctrl
    import stby_pkg::*;
#(
    parameter int               N_IRQ         = 6,
    parameter logic [N_IRQ-1:0] IRQ_WAKE_MASK = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wait_done,
    input  logic             bus_idle,
    input  logic             ext_req,
    input  logic [N_IRQ-1:0] irq,
    input  logic             nmi,
    input  logic             reset_req,
    input  logic             cold_reset_req,
    output logic             core_clk_en,
    output logic             stby_flag,
    output logic             irq_en_set
);
    stby_evt_t   evt;
    stby_state_e state;

    stby_wake_detect #(
        .N_IRQ        (N_IRQ),
        .IRQ_WAKE_MASK(IRQ_WAKE_MASK)
    ) wake_i (
        .irq           (irq),
        .nmi           (nmi),
        .wait_done     (wait_done),
        .bus_idle      (bus_idle),
        .ext_req       (ext_req),
        .reset_req     (reset_req),
        .cold_reset_req(cold_reset_req),
        .evt           (evt)
    );

    stby_seq_fsm fsm_i (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .state(state)
    );

    stby_out_stage out_i (
        .clk        (clk),
        .rst        (rst),
        .state      (state),
        .evt        (evt),
        .core_clk_en(core_clk_en),
        .stby_flag  (stby_flag),
        .irq_en_set (irq_en_set)
    );
endmodule

// File: rtl/stby_gate_chk.sv
module stby_gate_chk #(
    parameter int               N_IRQ         = 6,
    parameter logic [N_IRQ-1:0] IRQ_WAKE_MASK = '1
) (
    input logic             clk,
    input logic             rst,
    input logic             wait_done,
    input logic             bus_idle,
    input logic             ext_req,
    input logic [N_IRQ-1:0] irq,
    input logic             nmi,
    input logic             reset_req,
    input logic             cold_reset_req,
    input logic             core_clk_en,
    input logic             stby_flag,
    input logic             irq_en_set
);
    logic wk, frc, qt;
    assign wk  = (|(irq & IRQ_WAKE_MASK)) | nmi;
    assign frc = reset_req | cold_reset_req;
    assign qt  = bus_idle & ~ext_req;

    p_enter_r2: assert property (@(posedge clk) disable iff (rst)
        (!stby_flag && wait_done && qt && !wk && !frc) |=> stby_flag);

    p_busy_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!stby_flag && wait_done && !qt) |=> core_clk_en);

    p_wake_r6: assert property (@(posedge clk) disable iff (rst)
        (stby_flag && wk) |=> core_clk_en);

    p_stay_r7: assert property (@(posedge clk) disable iff (rst)
        (stby_flag && !wk && !frc) |=> stby_flag);

    p_force_r8: assert property (@(posedge clk) disable iff (rst)
        frc |=> (core_clk_en && !stby_flag));

    p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        (wait_done && !frc && !stby_flag) |=> irq_en_set);

    p_no_entry_r11: assert property (@(posedge clk) disable iff (rst)
        (!stby_flag && wait_done && wk) |=> core_clk_en);

    always_comb begin
        if (!rst) begin
            a_flag_r10: assert (stby_flag == !core_clk_en);
        end
    end
endmodule

bind stby_gate_ctrl stby_gate_chk #(
    .N_IRQ        (N_IRQ),
    .IRQ_WAKE_MASK(IRQ_WAKE_MASK)
) chk_i (.*);

// File: tb/stby_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module stby_gate_ctrl_tb_top;
    localparam int NI = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          wait_done, bus_idle, ext_req, nmi, reset_req, cold_reset_req;
    logic [NI-1:0] irq;
    logic          core_clk_en, stby_flag, irq_en_set;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;
    bit  m_stby = 0, m_pend = 0, m_pulse = 0;

    always #2 clk = ~clk;

    stby_gate_ctrl #(.N_IRQ(NI)) dut_i (
        .clk(clk), .rst(rst), .wait_done(wait_done), .bus_idle(bus_idle),
        .ext_req(ext_req), .irq(irq), .nmi(nmi), .reset_req(reset_req),
        .cold_reset_req(cold_reset_req), .core_clk_en(core_clk_en),
        .stby_flag(stby_flag), .irq_en_set(irq_en_set)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "stby_flag", stby_flag, m_stby);
        check(tag, "core_clk_en", core_clk_en, !m_stby);
        check(tag, "irq_en_set", irq_en_set, m_pulse);
        check("R10", "flag_vs_en", stby_flag, !core_clk_en);
    endtask

    // one clock: drive at negedge, model the edge, sample 1ns after it
    task automatic cyc(input string tag, input bit wd, input bit idle, input bit ex,
                       input logic [NI-1:0] iv, input bit nv, input bit rr, input bit cr);
        bit frc, wk, qt;
        @(negedge clk);
        wait_done = wd; bus_idle = idle; ext_req = ex; irq = iv; nmi = nv;
        reset_req = rr; cold_reset_req = cr;
        frc = rr | cr; wk = (|iv) | nv; qt = idle & !ex;
        m_pulse = wd & !frc & !m_stby;
        if (frc) begin
            m_stby = 0; m_pend = 0;
        end else if (m_stby) begin
            if (wk) m_stby = 0;
        end else if (m_pend) begin
            if (wk) m_pend = 0;
            else if (qt) begin m_stby = 1; m_pend = 0; end
        end else if (wd && !wk) begin
            if (qt) m_stby = 1; else m_pend = 1;
        end
        @(posedge clk);
        #1;
        check_all(tag);
    endtask

    task automatic quiet(input string tag);
        cyc(tag, 0, 1, 0, '0, 0, 0, 0);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; wait_done = 0; bus_idle = 1; ext_req = 0; irq = '0; nmi = 0;
        reset_req = 0; cold_reset_req = 0;
        repeat (3) @(posedge clk);
        #1;
        check_all("R1");
        @(negedge clk); rst = 0;
        @(posedge clk); #1;
        check_all("R1");

        // exhaustive sweep from running state: wd, idle, ext, wake, force
        for (int c = 0; c < 32; c++) begin
            bit wd, idle, ex, wk, frc;
            string tg;
            {wd, idle, ex, wk, frc} = c[4:0];
            if (frc)                  tg = "R8";
            else if (wd && wk)        tg = "R11";
            else if (wd && (!idle || ex)) tg = "R3";
            else if (wd)              tg = "R2";
            else                      tg = "R9";
            cyc(tg, wd, idle, ex, wk ? 6'b000001 : '0, 0, frc, 0);
            cyc("R9", 0, 0, 0, '0, 0, 0, 0);          // pulse gone; busy so pending holds
            cyc("R8", 0, 1, 0, '0, 0, 1, 0);          // clears any state
            check("R8", "pending_cleared_en", core_clk_en, 1);
        end

        // wake from each source, with ignored activity in standby
        for (int s = 0; s <= NI; s++) begin
            cyc("R2", 1, 1, 0, '0, 0, 0, 0);
            cyc("R7", 0, 0, 1, '0, 0, 0, 0);
            cyc("R7", 1, 1, 1, '0, 0, 0, 0);
            cyc("R7", 0, 0, 0, '0, 0, 0, 0);
            if (s < NI) cyc("R6", 0, 1, 0, NI'(1) << s, 0, 0, 0);
            else        cyc("R6", 0, 1, 0, '0, 1, 0, 0);
            quiet("R6");
        end

        // pending entry taken after a varying busy delay
        for (int d = 0; d < 6; d++) begin
            cyc("R3", 1, 0, 0, '0, 0, 0, 0);
            for (int k = 0; k < d; k++)
                cyc("R3", 0, (k % 2) == 0, 1, '0, 0, 0, 0);
            cyc("R4", 0, 1, 0, '0, 0, 0, 0);
            cyc("R6", 0, 1, 0, 6'b100000, 0, 0, 0);
        end

        // pending cancelled by interrupt, then by each reset request
        cyc("R3", 1, 0, 0, '0, 0, 0, 0);
        cyc("R5", 0, 0, 0, 6'b000100, 0, 0, 0);
        cyc("R5", 0, 1, 0, '0, 0, 0, 0);
        cyc("R5", 0, 1, 0, '0, 0, 0, 0);
        cyc("R3", 1, 1, 1, '0, 0, 0, 0);
        cyc("R8", 0, 0, 0, '0, 0, 0, 1);
        cyc("R8", 0, 1, 0, '0, 0, 0, 0);
        cyc("R2", 1, 1, 0, '0, 0, 0, 0);
        cyc("R8", 0, 1, 0, '0, 0, 0, 1);
        cyc("R2", 1, 1, 0, '0, 0, 0, 0);
        cyc("R8", 0, 1, 0, '0, 0, 1, 0);
        cyc("R11", 1, 1, 0, '0, 1, 0, 0);
        quiet("R11");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule